// File: doc/BRIEF.md
# Cascadable Dual 8-bit Event Counter

This block counts events with two 8-bit up-counting halves joined into a single 16-bit counter. The lower half advances on each qualified count pulse. The upper half advances only when the lower half carries out of its all-ones value. The count source is either an external event pin or one of three fixed divisions of the system clock. When the pin is the source, it is synchronized before edge detection. The edges that count are falling, rising or both. No count pulse reaches the counter while the gate input is low.

Each half has a run bit and an active-low zeroing bit. To start the counter cleanly, software drives both zeroing bits low with the run bits low, clears the overflow flag, and then raises all four bits. A carry out of the full 16-bit value wraps the count to zero. It also sets a sticky overflow flag and a sticky interrupt-request flag, and the interrupt output follows the request flag only while the interrupt enable is high. The whole design is synchronous to one clock. Divided-clock sources are one-cycle enables, not derived clocks.

Top module: `cascade_event_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `count_val` is 0x0000 and `ovf_flag`, `irq_flag` and `irq_out` are low until the first counted event.
- R2: With `src_sel` = 00 the pin is the source. `edge_sel` 00 counts falling edges, 01 counts rising edges, and 10 or 11 count both edges. A pin change held for at least two clocks shows in `count_val` after the third rising clock edge following the change.
- R3: `src_sel` 01, 10 and 11 count once every 2, 4 and 8 clocks respectively, with one count per period.
- R4: While `gate_en` is low no count occurs and `count_val` holds.
- R5: `run_en[0]` low freezes the lower byte. `run_en[1]` low freezes the upper byte. The upper byte (bits 15:8) advances only in the cycle where the lower byte (bits 7:0) steps from 0xFF to 0x00.
- R6: `clr_n[i]` low forces half i to 0x00 at the next clock edge, and this takes priority over counting.
- R7: A count with `count_val` = 0xFFFF gives 0x0000 and sets both `ovf_flag` and `irq_flag`, and counting continues afterwards.
- R8: `irq_out` is high exactly when `irq_flag` is high and `irq_en` is high.
- R9: A one-cycle `ovf_clr` or `irq_clr` strobe clears its flag at the next edge. Otherwise the flags stay set. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_pin | input | 1 | External event pin |
| gate_en | input | 1 | Count gate, high allows counting |
| src_sel | input | 2 | Count source: 00 pin, 01 clk/2, 10 clk/4, 11 clk/8 |
| edge_sel | input | 2 | Pin sensing: 00 falling, 01 rising, 1x both |
| run_en | input | 2 | Per-half count enable (bit 0 lower, bit 1 upper) |
| clr_n | input | 2 | Per-half active-low zeroing control |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| irq_clr | input | 1 | Clear strobe for the interrupt-request flag |
| irq_en | input | 1 | Interrupt enable |
| count_val | output | 16 | Current 16-bit count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_flag | output | 1 | Sticky interrupt-request flag |
| irq_out | output | 1 | Interrupt request output |

## Verification
The bench drives the counter through a complete wrap at 0xFFFF, holding the overflow clear strobe high across the wrap. A design that let the clear win would never show the overflow flag, and one that lost the carry into the upper byte would stall at 0x00FF. Pin counting is exercised in all three edge modes with the exact synchronizer latency, so an off-by-one pipeline or a swapped edge encoding shifts the count by a cycle or doubles it. The gate, frozen halves and zeroing controls are each applied while the source keeps producing pulses, which exposes a design that keeps counting behind a low gate or lets a count beat a zeroing request.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_DIV2 = 2'b01,
    SRC_DIV4 = 2'b10,
    SRC_DIV8 = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    EDG_FALL     = 2'b00,
    EDG_RISE     = 2'b01,
    EDG_BOTH     = 2'b10,
    EDG_BOTH_ALT = 2'b11
  } edge_sel_e;

endpackage

// File: rtl/evc_rst_sync.sv
module evc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/evc_pin_edge.sv
module evc_pin_edge
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_in,
  input  edge_sel_e edge_sel,
  output logic      evt_pulse
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   last_d;
  logic                   fall_seen;
  logic                   rise_seen;

  // Shift chain; the pin idles high, so reset state is all ones
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_in};
    last_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign fall_seen = last_q & ~sync_q[SYNC_STAGES-1];
  assign rise_seen = ~last_q & sync_q[SYNC_STAGES-1];

  always_comb begin
    unique case (edge_sel)
      EDG_FALL: evt_pulse = fall_seen;
      EDG_RISE: evt_pulse = rise_seen;
      default:  evt_pulse = fall_seen | rise_seen;
    endcase
  end

endmodule

// File: rtl/evc_tick_gen.sv
module evc_tick_gen
  import evc_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_e src_sel,
  input  logic     pin_pulse,
  input  logic     gate_en,
  output logic     tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] tap;
  logic             raw_tick;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // tap[k] pulses once every 2^(k+1) cycles
  for (genvar k = 0; k < PRE_W; k++) begin : g_tap
    assign tap[k] = &pre_q[k:0];
  end

  always_comb begin
    unique case (src_sel)
      SRC_PIN:  raw_tick = pin_pulse;
      SRC_DIV2: raw_tick = tap[0];
      SRC_DIV4: raw_tick = tap[1];
      default:  raw_tick = tap[2];
    endcase
  end

  assign tick = raw_tick & gate_en;

endmodule

// File: rtl/evc_half.sv
module evc_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_in,
  input  logic         run,
  input  logic         clr_n,
  output logic [W-1:0] value,
  output logic         carry_out
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         step_ok;

  assign step_ok = clr_n & run & step_in;

  always_comb begin
    if (!clr_n) begin
      val_d = '0;
    end else if (step_ok) begin
      val_d = val_q + 1'b1;
    end else begin
      val_d = val_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign value     = val_q;
  assign carry_out = step_ok & (&val_q);

endmodule

// File: rtl/cascade_event_counter.sv
module cascade_event_counter
  import evc_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int NUM_HALVES  = 2,
  parameter int PRE_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         evt_pin,
  input  logic                         gate_en,
  input  logic [1:0]                   src_sel,
  input  logic [1:0]                   edge_sel,
  input  logic [NUM_HALVES-1:0]        run_en,
  input  logic [NUM_HALVES-1:0]        clr_n,
  input  logic                         ovf_clr,
  input  logic                         irq_clr,
  input  logic                         irq_en,
  output logic [HALF_W*NUM_HALVES-1:0] count_val,
  output logic                         ovf_flag,
  output logic                         irq_flag,
  output logic                         irq_out
);

  localparam int CNT_W = HALF_W * NUM_HALVES;

  logic                  srst_n;
  logic                  pin_pulse;
  logic                  tick;
  logic [NUM_HALVES:0]   step_chain;
  logic                  wrap_pulse;
  logic                  ovf_q, ovf_d;
  logic                  irq_q, irq_d;

  evc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (srst_n)
  );

  evc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk       (clk),
    .rst_n     (srst_n),
    .pin_in    (evt_pin),
    .edge_sel  (edge_sel_e'(edge_sel)),
    .evt_pulse (pin_pulse)
  );

  evc_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst_n     (srst_n),
    .src_sel   (src_sel_e'(src_sel)),
    .pin_pulse (pin_pulse),
    .gate_en   (gate_en),
    .tick      (tick)
  );

  assign step_chain[0] = tick;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    evc_half #(.W(HALF_W)) u_half (
      .clk       (clk),
      .rst_n     (srst_n),
      .step_in   (step_chain[g]),
      .run       (run_en[g]),
      .clr_n     (clr_n[g]),
      .value     (count_val[g*HALF_W +: HALF_W]),
      .carry_out (step_chain[g+1])
    );
  end

  assign wrap_pulse = step_chain[NUM_HALVES];

  // Sticky flags: a set in the same cycle as a clear strobe wins
  always_comb begin
    ovf_d = ovf_q;
    irq_d = irq_q;
    if (ovf_clr)    ovf_d = 1'b0;
    if (irq_clr)    irq_d = 1'b0;
    if (wrap_pulse) begin
      ovf_d = 1'b1;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      irq_q <= irq_d;
    end
  end

  assign ovf_flag = ovf_q;
  assign irq_flag = irq_q;
  assign irq_out  = irq_q & irq_en;

  logic unused_width;
  assign unused_width = ^CNT_W;

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         gate_en,
  input logic [NUM_HALVES-1:0]        clr_n,
  input logic                         irq_clr,
  input logic                         irq_en,
  input logic [HALF_W*NUM_HALVES-1:0] count_val,
  input logic                         ovf_flag,
  input logic                         irq_flag,
  input logic                         irq_out
);

  // R4: a low gate with no zeroing request leaves the count unchanged
  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && (&clr_n)) |=> $stable(count_val));

  // R6: zeroing the lower half lands at the next edge
  assert_lower_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n[0] |=> (count_val[HALF_W-1:0] == '0));

  // R5: the upper byte moves only on a lower-byte carry
  assert_upper_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_n[1]) && (count_val[2*HALF_W-1:HALF_W] != $past(count_val[2*HALF_W-1:HALF_W])))
    |-> (($past(count_val[HALF_W-1:0]) == {HALF_W{1'b1}}) && (count_val[HALF_W-1:0] == '0)));

  // R7: a rising overflow flag coincides with a wrapped count
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count_val == '0));

  // R9: the request flag stays set without a clear strobe
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R8: the output never rises while disabled
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || !irq_flag) |-> !irq_out);

endmodule

bind cascade_event_counter evc_checker #(
  .HALF_W     (HALF_W),
  .NUM_HALVES (NUM_HALVES)
) u_evc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_en   (gate_en),
  .clr_n     (clr_n),
  .irq_clr   (irq_clr),
  .irq_en    (irq_en),
  .count_val (count_val),
  .ovf_flag  (ovf_flag),
  .irq_flag  (irq_flag),
  .irq_out   (irq_out)
);

// File: tb/cascade_event_counter_test.sv
`timescale 1ns/1ps
module cascade_event_counter_test;

  logic        clk;
  logic        rst_n;
  logic        evt_pin;
  logic        gate_en;
  logic [1:0]  src_sel;
  logic [1:0]  edge_sel;
  logic [1:0]  run_en;
  logic [1:0]  clr_n;
  logic        ovf_clr;
  logic        irq_clr;
  logic        irq_en;
  logic [15:0] count_val;
  logic        ovf_flag;
  logic        irq_flag;
  logic        irq_out;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    cmp_on   = 0;
  bit    finished = 0;
  string phase    = "R1 reset";

  cascade_event_counter uut (
    .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .gate_en(gate_en),
    .src_sel(src_sel), .edge_sel(edge_sel), .run_en(run_en), .clr_n(clr_n),
    .ovf_clr(ovf_clr), .irq_clr(irq_clr), .irq_en(irq_en),
    .count_val(count_val), .ovf_flag(ovf_flag), .irq_flag(irq_flag), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_age, m_pre, m_cnt;
  int m_s1, m_s2, m_s3;
  bit m_ovf, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_age = 0; m_pre = 0; m_cnt = 0;
      m_s1 = 1; m_s2 = 1; m_s3 = 1;
      m_ovf = 0; m_irq = 0;
    end else begin
      if (m_age >= 2) begin
        int lo, hi, div;
        bit tk, carry, wrap;
        lo = m_cnt % 256;
        hi = m_cnt / 256;
        if (src_sel == 2'b00) begin
          if (edge_sel == 2'b00)      tk = (m_s3 == 1) && (m_s2 == 0);
          else if (edge_sel == 2'b01) tk = (m_s3 == 0) && (m_s2 == 1);
          else                        tk = (m_s3 != m_s2);
        end else begin
          div = 1 << src_sel;
          tk  = (m_pre % div) == (div - 1);
        end
        tk    = tk && gate_en;
        carry = tk && run_en[0] && clr_n[0] && (lo == 255);
        wrap  = carry && run_en[1] && clr_n[1] && (hi == 255);
        if (!clr_n[0]) lo = 0;
        else if (run_en[0] && tk) lo = (lo + 1) % 256;
        if (!clr_n[1]) hi = 0;
        else if (run_en[1] && carry) hi = (hi + 1) % 256;
        m_cnt = hi * 256 + lo;
        if (wrap) begin m_ovf = 1; m_irq = 1; end
        else begin
          if (ovf_clr) m_ovf = 0;
          if (irq_clr) m_irq = 0;
        end
        m_pre = (m_pre + 1) % 8;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(evt_pin);
      end
      m_age = m_age + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(count_val == 16'(m_cnt), {phase, " count"}, count_val, m_cnt);
      chk(ovf_flag == m_ovf, {phase, " ovf (R7/R9)"}, ovf_flag, m_ovf);
      chk(irq_flag == m_irq, {phase, " irq flag (R7/R9)"}, irq_flag, m_irq);
      chk(irq_out == (m_irq && irq_en), {phase, " irq out R8"}, irq_out, m_irq && irq_en);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c0;
    rst_n = 0; evt_pin = 1; gate_en = 0; src_sel = 2'b00; edge_sel = 2'b00;
    run_en = 2'b00; clr_n = 2'b00; ovf_clr = 0; irq_clr = 0; irq_en = 0;
    step(3);
    chk(count_val == 16'h0 && !ovf_flag && !irq_flag && !irq_out, "R1 in reset",
        {count_val, ovf_flag, irq_flag, irq_out}, 0);
    rst_n = 1;
    step(4);
    chk(count_val == 16'h0 && !ovf_flag && !irq_flag, "R1 after release", count_val, 0);
    cmp_on = 1;

    // start sequence: zero and stopped, flags cleared, then run
    ovf_clr = 1; irq_clr = 1; step(1); ovf_clr = 0; irq_clr = 0;
    clr_n = 2'b11; run_en = 2'b11; gate_en = 1;

    phase = "R2 falling";
    for (int i = 0; i < 5; i++) begin evt_pin = 0; step(4); evt_pin = 1; step(4); end
    chk(count_val == 16'd5, "R2 falling edges", count_val, 5);

    phase = "R2 latency";
    evt_pin = 0; step(2);
    chk(count_val == 16'd5, "R2 two clocks after change", count_val, 5);
    step(1);
    chk(count_val == 16'd6, "R2 third clock after change", count_val, 6);
    evt_pin = 1; step(4);

    phase = "R2 rising"; edge_sel = 2'b01;
    for (int i = 0; i < 5; i++) begin evt_pin = 0; step(4); evt_pin = 1; step(4); end
    chk(count_val == 16'd11, "R2 rising edges", count_val, 11);

    phase = "R2 both"; edge_sel = 2'b10;
    for (int i = 0; i < 5; i++) begin evt_pin = 0; step(3); evt_pin = 1; step(3); end
    step(3);
    chk(count_val == 16'd21, "R2 both edges", count_val, 21);

    phase = "R4 gate low"; gate_en = 0;
    for (int i = 0; i < 5; i++) begin evt_pin = 0; step(4); evt_pin = 1; step(4); end
    chk(count_val == 16'd21, "R4 gate blocks pin", count_val, 21);
    src_sel = 2'b01; step(16);
    chk(count_val == 16'd21, "R4 gate blocks divider", count_val, 21);
    gate_en = 1; edge_sel = 2'b00;

    phase = "R3 div2"; c0 = count_val; step(64);
    chk(int'(count_val) - c0 == 32, "R3 div2 rate", int'(count_val) - c0, 32);
    phase = "R3 div4"; src_sel = 2'b10; c0 = count_val; step(64);
    chk(int'(count_val) - c0 == 16, "R3 div4 rate", int'(count_val) - c0, 16);
    phase = "R3 div8"; src_sel = 2'b11; c0 = count_val; step(64);
    chk(int'(count_val) - c0 == 8, "R3 div8 rate", int'(count_val) - c0, 8);

    phase = "R5 upper frozen"; src_sel = 2'b01; run_en = 2'b01; c0 = count_val; step(40);
    chk(int'(count_val) - c0 == 20, "R5 lower runs alone", int'(count_val) - c0, 20);
    phase = "R5 lower frozen"; run_en = 2'b10; c0 = count_val; step(40);
    chk(int'(count_val) == c0, "R5 lower frozen", count_val, c0);
    run_en = 2'b11;

    phase = "R6 zeroing"; clr_n = 2'b10; step(1);
    chk(count_val[7:0] == 8'h00, "R6 lower forced to zero", count_val[7:0], 0);
    step(5);
    chk(count_val == 16'h0, "R6 held at zero while counting", count_val, 0);
    clr_n = 2'b11;

    phase = "R7 long run"; irq_en = 0;
    for (int i = 0; i < 140000 && count_val != 16'hFFF0; i++) step(1);
    ovf_clr = 1;
    for (int i = 0; i < 64 && count_val != 16'h0000; i++) step(1);
    chk(count_val == 16'h0000, "R7 wrapped to zero", count_val, 0);
    chk(ovf_flag == 1'b1, "R9 set wins over clear", ovf_flag, 1);
    step(1);
    ovf_clr = 0;
    chk(ovf_flag == 1'b0, "R9 clear after set", ovf_flag, 0);
    chk(irq_flag == 1'b1, "R7 request flag set", irq_flag, 1);
    chk(irq_out == 1'b0, "R8 masked output", irq_out, 0);
    step(10);
    chk(count_val != 16'h0 && count_val < 16'd16, "R7 counting continues", count_val, 6);
    phase = "R8 enable"; irq_en = 1; step(1);
    chk(irq_out == 1'b1, "R8 enabled output", irq_out, 1);
    phase = "R9 irq clear"; irq_clr = 1; step(1); irq_clr = 0;
    chk(irq_flag == 1'b0 && irq_out == 1'b0, "R9 request cleared", irq_flag, 0);
    step(8);
    finish_run();
  end

endmodule